// File: doc/BRIEF.md
# Interrupt Priority Masking Filter

This block sits between a set of interrupt sources and a processor core. Each cycle it looks at which sources are pending and at the priority value of each. It applies three software-held masks to that set. Then it tells the core whether an interrupt may be taken and which source that is. The decision is combinational, so a change in the pending set or in the mask state shows on the outputs in the same cycle.

Urgency runs on an inverted scale: a smaller priority value is more urgent. The three masks work independently of each other.
- A priority threshold blocks any maskable source whose value is not below it.
- A global mask bit blocks everything except the non-maskable source and the hard-fault source.
- A fault mask bit blocks everything except the non-maskable source.

Two per-source flag vectors mark which inputs are the non-maskable source and which are the hard-fault source. The mask registers are written through a small address/data port. Their contents are always visible on readback outputs.

Top module: `ipf_filter`

## Requirements
- R1: After reset the global mask, fault mask and threshold all read 0, so a pending source of any priority value is taken.
- R2: A write with `cfg_wr_en` high updates one register at the next rising clock edge. Address 0 loads the global mask from data bit 0, address 1 loads the fault mask from data bit 0, and address 2 loads the threshold from the full data field. Address 3 changes nothing.
- R3: With a non-zero threshold, a source that is neither non-maskable nor hard-fault is blocked when its priority value is greater than or equal to the threshold, and passes when its value is below it. A threshold of 0 blocks nothing.
- R4: With the global mask set, only sources flagged non-maskable or hard-fault can be taken.
- R5: With the fault mask set, only sources flagged non-maskable can be taken. This includes blocking the hard-fault source.
- R6: Sources flagged non-maskable or hard-fault are never blocked by the threshold.
- R7: Among passing sources that are not non-maskable, the one with the smallest priority value is selected. On equal values, the lowest source number wins.
- R8: If any pending source flagged non-maskable is present, a non-maskable source is selected, whatever the priority values of the others.
- R9: `irq_take` is high in the same cycle exactly when at least one pending source passes all masks, and `irq_id` is 0 whenever `irq_take` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the mask registers |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_pend | input | NUM_SRC | Pending flag per source |
| src_prio | input | NUM_SRC*PRIO_W | Priority value per source, source i in bits [i*PRIO_W +: PRIO_W] |
| src_is_nmi | input | NUM_SRC | Marks sources that are non-maskable |
| src_is_hf | input | NUM_SRC | Marks sources that are hard-fault |
| cfg_wr_en | input | 1 | Register write strobe |
| cfg_wr_addr | input | 2 | Register select for a write |
| cfg_wr_data | input | PRIO_W | Write data |
| irq_take | output | 1 | An unmasked pending source exists |
| irq_id | output | $clog2(NUM_SRC) | Number of the selected source |
| gmask_q | output | 1 | Global mask readback |
| fmask_q | output | 1 | Fault mask readback |
| thresh_q | output | PRIO_W | Threshold readback |

## Verification
Selection is tried with three pending sets:
- distinct values with the most urgent source at the top index, which separates a smaller-value-wins order from a lowest-index order;
- two sources tied on value, which shows the tie rule;
- an all-blocked set, which shows that the output number goes to zero.

Each mask is tried alone. Under each one, the bench places a non-maskable source, a hard-fault source and an ordinary source of value 0, which shows which exemption each mask honours. The threshold is probed at the value itself, one below it and at 0, to pin the blocking edge and the disabled case. The non-maskable flag is moved to a different source number, which proves that the override follows the flag and not a fixed position.

// File: rtl/ipf_pkg.sv
package ipf_pkg;

   // Register select codes on the configuration write port
   typedef enum logic [1:0] {
      SEL_GMASK  = 2'd0,
      SEL_FMASK  = 2'd1,
      SEL_THRESH = 2'd2,
      SEL_NONE   = 2'd3
   } ipf_sel_e;

endpackage

// File: rtl/ipf_regs.sv
module ipf_regs
   import ipf_pkg::*;
#(
   parameter int PRIO_W = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [1:0]        wr_addr,
   input  logic [PRIO_W-1:0] wr_data,
   output logic              gmask,
   output logic              fmask,
   output logic [PRIO_W-1:0] thresh
);

   ipf_sel_e sel;
   assign sel = ipf_sel_e'(wr_addr);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         gmask  <= 1'b0;
         fmask  <= 1'b0;
         thresh <= '0;
      end else if (wr_en) begin
         case (sel)
            SEL_GMASK:  gmask  <= wr_data[0];
            SEL_FMASK:  fmask  <= wr_data[0];
            SEL_THRESH: thresh <= wr_data;
            default:    ;
         endcase
      end
   end

   // R2: each select code lands in its own register on the next edge
   p_gmask_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_addr == 2'd0) |=> (gmask == $past(wr_data[0])));
   p_fmask_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_addr == 2'd1) |=> (fmask == $past(wr_data[0])));
   p_thresh_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_addr == 2'd2) |=> (thresh == $past(wr_data)));
   p_idle_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (!wr_en || wr_addr == 2'd3) |=> ($stable(gmask) && $stable(fmask) && $stable(thresh)));

endmodule

// File: rtl/ipf_gate.sv
module ipf_gate #(
   parameter int NUM_SRC = 8,
   parameter int PRIO_W  = 4
) (
   input  logic [NUM_SRC-1:0]        pend,
   input  logic [NUM_SRC*PRIO_W-1:0] prio_flat,
   input  logic [NUM_SRC-1:0]        nmi_map,
   input  logic [NUM_SRC-1:0]        hf_map,
   input  logic                      gmask,
   input  logic                      fmask,
   input  logic [PRIO_W-1:0]         thresh,
   output logic [NUM_SRC-1:0]        pass,
   output logic [NUM_SRC-1:0]        urgent
);

   logic thr_on;
   assign thr_on = (thresh != '0);

   for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
      logic [PRIO_W-1:0] p;
      logic              below;
      logic              ordinary_ok;
      logic              hf_ok;

      assign p           = prio_flat[i*PRIO_W +: PRIO_W];
      assign below       = !thr_on || (p < thresh);
      assign ordinary_ok = !gmask && !fmask && below;
      assign hf_ok       = !fmask;
      assign pass[i]     = pend[i] && (nmi_map[i] || (hf_map[i] ? hf_ok : ordinary_ok));
      assign urgent[i]   = pass[i] && nmi_map[i];
   end

endmodule

// File: rtl/ipf_arb.sv
module ipf_arb #(
   parameter int NUM_SRC  = 8,
   parameter int PRIO_W   = 4,
   parameter bit ARB_TREE = 1'b0
) (
   input  logic [NUM_SRC-1:0]         pass,
   input  logic [NUM_SRC-1:0]         urgent,
   input  logic [NUM_SRC*PRIO_W-1:0]  prio_flat,
   output logic                       any,
   output logic [$clog2(NUM_SRC)-1:0] win_id
);

   localparam int IDW  = $clog2(NUM_SRC);
   localparam int KW   = PRIO_W + 2;
   localparam int NPAD = 1 << IDW;

   // Ordering key: smaller wins. Blocked sources sort last, then
   // non-maskable ahead of the rest, then by priority value.
   logic [KW-1:0] key [NUM_SRC];

   for (genvar i = 0; i < NUM_SRC; i++) begin : g_key
      assign key[i] = {~pass[i], ~urgent[i], prio_flat[i*PRIO_W +: PRIO_W]};
   end

   assign any = |pass;

   if (ARB_TREE) begin : g_tree
      logic [KW-1:0]  nk  [2*NPAD];
      logic [IDW-1:0] nid [2*NPAD];

      assign nk[0]  = '1;
      assign nid[0] = '0;

      for (genvar j = 0; j < NPAD; j++) begin : g_leaf
         if (j < NUM_SRC) begin : g_real
            assign nk[NPAD+j] = key[j];
         end else begin : g_pad
            assign nk[NPAD+j] = '1;
         end
         assign nid[NPAD+j] = IDW'(j);
      end

      for (genvar k = NPAD-1; k >= 1; k--) begin : g_node
         logic left_wins;
         assign left_wins = (nk[2*k] <= nk[2*k+1]);
         assign nk[k]     = left_wins ? nk[2*k]  : nk[2*k+1];
         assign nid[k]    = left_wins ? nid[2*k] : nid[2*k+1];
      end

      assign win_id = nid[1];
   end else begin : g_linear
      logic [KW-1:0]  best_k;
      logic [IDW-1:0] best_i;

      always_comb begin
         best_k = key[0];
         best_i = '0;
         for (int i = 1; i < NUM_SRC; i++) begin
            if (key[i] < best_k) begin
               best_k = key[i];
               best_i = IDW'(i);
            end
         end
      end

      assign win_id = best_i;
   end

endmodule

// File: rtl/ipf_filter.sv
module ipf_filter #(
   parameter int NUM_SRC  = 8,
   parameter int PRIO_W   = 4,
   parameter bit ARB_TREE = 1'b0
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic [NUM_SRC-1:0]          src_pend,
   input  logic [NUM_SRC*PRIO_W-1:0]   src_prio,
   input  logic [NUM_SRC-1:0]          src_is_nmi,
   input  logic [NUM_SRC-1:0]          src_is_hf,
   input  logic                        cfg_wr_en,
   input  logic [1:0]                  cfg_wr_addr,
   input  logic [PRIO_W-1:0]           cfg_wr_data,
   output logic                        irq_take,
   output logic [$clog2(NUM_SRC)-1:0]  irq_id,
   output logic                        gmask_q,
   output logic                        fmask_q,
   output logic [PRIO_W-1:0]           thresh_q
);

   localparam int IDW = $clog2(NUM_SRC);

   if (NUM_SRC < 2) begin : g_chk_src
      $error("ipf_filter: NUM_SRC must be at least 2");
   end
   if (PRIO_W < 1 || PRIO_W > 16) begin : g_chk_prio
      $error("ipf_filter: PRIO_W must lie in 1..16");
   end

   logic [NUM_SRC-1:0] pass;
   logic [NUM_SRC-1:0] urgent;
   logic               any;
   logic [IDW-1:0]     win_id;

   ipf_regs #(.PRIO_W(PRIO_W)) u_regs (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (cfg_wr_en),
      .wr_addr (cfg_wr_addr),
      .wr_data (cfg_wr_data),
      .gmask   (gmask_q),
      .fmask   (fmask_q),
      .thresh  (thresh_q)
   );

   ipf_gate #(.NUM_SRC(NUM_SRC), .PRIO_W(PRIO_W)) u_gate (
      .pend      (src_pend),
      .prio_flat (src_prio),
      .nmi_map   (src_is_nmi),
      .hf_map    (src_is_hf),
      .gmask     (gmask_q),
      .fmask     (fmask_q),
      .thresh    (thresh_q),
      .pass      (pass),
      .urgent    (urgent)
   );

   ipf_arb #(.NUM_SRC(NUM_SRC), .PRIO_W(PRIO_W), .ARB_TREE(ARB_TREE)) u_arb (
      .pass      (pass),
      .urgent    (urgent),
      .prio_flat (src_prio),
      .any       (any),
      .win_id    (win_id)
   );

   assign irq_take = any;
   assign irq_id   = any ? win_id : '0;

   // Per-source view of the priority field for the checks below
   logic [PRIO_W-1:0] prio_a [NUM_SRC];
   for (genvar i = 0; i < NUM_SRC; i++) begin : g_pa
      assign prio_a[i] = src_prio[i*PRIO_W +: PRIO_W];
   end

   p_reset_clear_r1: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (!gmask_q && !fmask_q && thresh_q == '0));
   p_sel_pending_r9: assert property (@(posedge clk) disable iff (!rst_n)
      irq_take |-> src_pend[irq_id]);
   p_idle_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !irq_take |-> (irq_id == '0));
   p_thresh_block_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_take && thresh_q != '0 && !src_is_nmi[irq_id] && !src_is_hf[irq_id])
         |-> (prio_a[irq_id] < thresh_q));
   p_gmask_exempt_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_take && gmask_q) |-> (src_is_nmi[irq_id] || src_is_hf[irq_id]));
   p_fmask_exempt_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_take && fmask_q) |-> src_is_nmi[irq_id]);
   p_nmi_first_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (|(src_pend & src_is_nmi)) |-> (irq_take && src_is_nmi[irq_id]));

endmodule

// File: tb/ipf_filter_tb.sv
module ipf_filter_tb;

   localparam int N  = 8;
   localparam int PW = 4;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [N-1:0]  pend = '0;
   logic [N*PW-1:0] prio = '0;
   logic [N-1:0]  nmi_m = 8'b0000_0001;
   logic [N-1:0]  hf_m  = 8'b0000_0010;
   logic          wr_en = 1'b0;
   logic [1:0]    wr_addr = '0;
   logic [PW-1:0] wr_data = '0;
   logic          take;
   logic [2:0]    id;
   logic          gm, fm;
   logic [PW-1:0] th;

   int total = 0;
   int bad = 0;

   always #5 clk = ~clk;

   ipf_filter #(.NUM_SRC(N), .PRIO_W(PW)) u_dut (
      .clk(clk), .rst_n(rst_n), .src_pend(pend), .src_prio(prio),
      .src_is_nmi(nmi_m), .src_is_hf(hf_m), .cfg_wr_en(wr_en),
      .cfg_wr_addr(wr_addr), .cfg_wr_data(wr_data), .irq_take(take),
      .irq_id(id), .gmask_q(gm), .fmask_q(fm), .thresh_q(th)
   );

   task automatic chk(input string req, input int act, input int exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic chk_irq(input string req, input bit exp_take, input int exp_id);
      chk({req, " take"}, int'(take), int'(exp_take));
      chk({req, " id"}, int'(id), exp_id);
   endtask

   task automatic set_src(input int s, input bit p, input int v);
      pend[s] = p;
      prio[s*PW +: PW] = PW'(v);
   endtask

   task automatic clear_src();
      pend = '0;
      prio = '0;
   endtask

   task automatic settle();
      #1;
   endtask

   task automatic wr(input int a, input int d);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = 2'(a); wr_data = PW'(d);
      @(posedge clk);
      #1;
      wr_en = 1'b0;
   endtask

   task automatic clear_regs();
      wr(0, 0); wr(1, 0); wr(2, 0);
   endtask

   task automatic t_reset();
      chk("R1 gmask", int'(gm), 0);
      chk("R1 fmask", int'(fm), 0);
      chk("R1 thresh", int'(th), 0);
      clear_src(); set_src(5, 1, 15); settle();
      chk_irq("R1 nothing masked", 1'b1, 5);
      clear_src(); settle();
      chk_irq("R9 idle", 1'b0, 0);
   endtask

   task automatic t_write();
      wr(0, 3);
      chk("R2 gmask bit0", int'(gm), 1);
      wr(1, 1);
      chk("R2 fmask", int'(fm), 1);
      wr(2, 9);
      chk("R2 thresh", int'(th), 9);
      wr(3, 0);
      chk("R2 addr3 gmask", int'(gm), 1);
      chk("R2 addr3 fmask", int'(fm), 1);
      chk("R2 addr3 thresh", int'(th), 9);
      wr(0, 2);
      chk("R2 gmask uses bit0", int'(gm), 0);
      clear_regs();
   endtask

   task automatic t_select();
      clear_src();
      set_src(2, 1, 6); set_src(4, 1, 3); set_src(5, 1, 3); set_src(7, 1, 1);
      settle();
      chk_irq("R7 smallest value", 1'b1, 7);
      set_src(7, 0, 1); settle();
      chk_irq("R7 tie lowest index", 1'b1, 4);
      clear_src();
      for (int s = 2; s < N; s++) set_src(s, 1, 8);
      settle();
      chk_irq("R7 all equal", 1'b1, 2);
      clear_src();
   endtask

   task automatic t_thresh();
      wr(2, 4);
      clear_src(); set_src(3, 1, 4); set_src(4, 1, 5); settle();
      chk_irq("R3 at and above threshold", 1'b0, 0);
      set_src(6, 1, 3); settle();
      chk_irq("R3 below threshold", 1'b1, 6);
      wr(2, 0);
      clear_src(); set_src(4, 1, 15); settle();
      chk_irq("R3 zero disables", 1'b1, 4);
      wr(2, 1);
      clear_src(); set_src(1, 1, 15); settle();
      chk_irq("R6 hard fault exempt", 1'b1, 1);
      clear_src(); set_src(0, 1, 15); set_src(3, 1, 0); settle();
      chk_irq("R6 nmi exempt", 1'b1, 0);
      clear_regs(); clear_src();
   endtask

   task automatic t_gmask();
      wr(0, 1);
      clear_src(); set_src(3, 1, 0); settle();
      chk_irq("R4 ordinary blocked", 1'b0, 0);
      set_src(1, 1, 9); settle();
      chk_irq("R4 hard fault passes", 1'b1, 1);
      set_src(0, 1, 12); settle();
      chk_irq("R4 nmi passes", 1'b1, 0);
      clear_regs(); clear_src();
   endtask

   task automatic t_fmask();
      wr(1, 1);
      clear_src(); set_src(1, 1, 0); set_src(3, 1, 0); settle();
      chk_irq("R5 hard fault blocked", 1'b0, 0);
      set_src(0, 1, 15); settle();
      chk_irq("R5 nmi passes", 1'b1, 0);
      clear_regs(); clear_src();
   endtask

   task automatic t_nmi();
      clear_src(); set_src(0, 1, 15); set_src(3, 1, 0); settle();
      chk_irq("R8 nmi over value 0", 1'b1, 0);
      nmi_m = 8'b0100_0000;
      clear_src(); set_src(6, 1, 15); set_src(2, 1, 0); set_src(0, 1, 0); settle();
      chk_irq("R8 flag follows map", 1'b1, 6);
      nmi_m = 8'b0000_0001;
      clear_src(); settle();
   endtask

   initial begin
      #(200000 * 10);
      bad++; total++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      @(posedge clk);
      #1;
      t_reset();
      t_write();
      t_select();
      t_thresh();
      t_gmask();
      t_fmask();
      t_nmi();
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule